// File: doc/BRIEF.md
# SPI Master Burst Engine

This block is the serial core of an SPI master. It moves 8-bit words from an external transmit FIFO onto the MOSI line and assembles the bits returned on MISO into words for an external receive FIFO. The bit clock comes from a one-cycle `tick` pulse produced elsewhere: every tick is one half period of SCLK. A control register inside the block selects clock polarity, sampling phase, bit order, which of four chip-select lines is used, its active level, a manual drive mode, and whether received words are thrown away.

One burst is launched by writing the control register with the start bit set while the enable and master bits are also set. The block latches two 24-bit counts when the burst begins. The burst count is the total number of words exchanged on the wire. The transmit count is how many of those words are taken from the transmit FIFO. Any words past the transmit count go out as zero. If the FIFO runs dry before the transmit count is used up, the engine waits with SCLK held at its idle level. When the last word has been exchanged, the block gives a one-cycle completion pulse and clears the start bit by itself.

Top module: `spi_burst_engine`

## Requirements
- R1: Control bit positions: 0 enable, 1 master, 2 phase, 3 polarity, 4 chip-select active low, 6 LSB first, 10 start, 13:12 chip-select index, 15 discard received, 16 manual chip select, 17 manual level. A start bit written while bit 0 or bit 1 is clear launches nothing: SCLK does not toggle, the FIFO is not popped, there is no completion pulse, and the start bit stays set.
- R2: A burst places exactly 8 × burst-count sampling edges on SCLK.
- R3: The first min(transmit count, burst count) words sent are popped from the transmit FIFO in FIFO order. Every later word of the burst is sent as 8'h00.
- R4: With bit 15 clear, each word received is pushed to the receive FIFO, one push per word, in the order received. With bit 15 set, no word is pushed.
- R5: While no burst is running, SCLK equals bit 3. With bit 2 clear, MISO is sampled on the first SCLK edge of each bit and MOSI changes on the second edge. With bit 2 set, MOSI changes on the first edge and MISO is sampled on the second edge.
- R6: With bit 6 clear, each word is sent and received MSB first. With bit 6 set, it is sent and received LSB first.
- R7: When a burst ends, `done` is high for exactly one cycle and the start bit reads back 0 in the following cycle.
- R8: In automatic mode (bit 16 clear), the line chosen by bits 13:12 is at its active level for the whole burst: 0 when bit 4 is set, 1 when bit 4 is clear. All other lines, and the chosen line when no burst is running, sit at the idle level, which equals bit 4.
- R9: In manual mode (bit 16 set), the chosen line carries the value of bit 17, whether or not a burst is running. The other lines stay at the idle level.
- R10: When the transmit count is not used up and the transmit FIFO is empty, the engine pops nothing and keeps SCLK at its idle level. It continues as soon as data arrives.
- R11: A burst with a burst count of zero completes with no SCLK edges and no FIFO traffic.
- R12: After reset, the control register is 0, SCLK and all chip-select lines are 0, and `done`, `tx_pop` and `rx_push` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 18 | Control value to write |
| ctl_q | output | 18 | Control register contents |
| burst_len | input | 24 | Total words in a burst, latched at start |
| tx_len | input | 24 | Words taken from the transmit FIFO, latched at start |
| tick | input | 1 | Half-period pulse for SCLK |
| tx_empty | input | 1 | Transmit FIFO is empty |
| tx_data | input | 8 | Head word of the transmit FIFO |
| tx_pop | output | 1 | Takes the head word of the transmit FIFO |
| rx_push | output | 1 | Writes `rx_data` into the receive FIFO |
| rx_data | output | 8 | Received word |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_o | output | 4 | Chip-select lines |
| done | output | 1 | One-cycle burst completion pulse |

## Verification
Between two words, the receive push of the word just finished and the transmit pop of the next word happen in the same cycle. That is the cycle where the engine returns to its load state. The bench causes this on every multi-word burst by keeping the FIFO filled ahead of time, with MISO looped back to MOSI. It then checks that the receive FIFO holds exactly the transmitted sequence, padding included, with neither a word lost nor a word repeated. The stall case moves the pop away from the push and waits for late data, and the same sequence check must still hold.

// File: rtl/spi_eng_pkg.sv
// Package: shared control-bit positions and engine state encoding.
// Assumes: the control register is 18 bits wide; software depends on the
// bit positions listed here, so they are fixed.
package spi_eng_pkg;
    localparam int CTL_W    = 18;
    localparam int CB_EN    = 0;
    localparam int CB_MST   = 1;
    localparam int CB_CPHA  = 2;
    localparam int CB_CPOL  = 3;
    localparam int CB_ACTLO = 4;
    localparam int CB_LSB   = 6;
    localparam int CB_GO    = 10;
    localparam int CB_SEL   = 12;
    localparam int CB_DROP  = 15;
    localparam int CB_MAN   = 16;
    localparam int CB_LVL   = 17;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LOAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } eng_state_t;
endpackage

// File: rtl/spi_eng_ctl.sv
// Control register. A write loads every bit. At the end of a burst the
// start bit is cleared, unless a write lands in the same cycle; the write wins.
// Assumes: xfer_done is a single-cycle pulse from the engine.
module spi_eng_ctl
    import spi_eng_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CTL_W-1:0] wr_data,
    input  logic             xfer_done,
    output logic [CTL_W-1:0] ctl_q
);
    // Hold the control bits; clear the start bit when the burst finishes.
    always_ff @(posedge clk) begin
        if (!rst_n)         ctl_q <= '0;
        else if (wr_en)     ctl_q <= wr_data;
        else if (xfer_done) ctl_q[CB_GO] <= 1'b0;
    end

    // R7: the start bit is cleared after completion.
    a_r7_start_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !wr_en) |=> !ctl_q[CB_GO]);
endmodule

// File: rtl/spi_eng_core.sv
// Burst shifter. It latches the burst and transmit counts, loads one word
// at a time (from the FIFO, or zero once the transmit count is used up),
// and spends two ticks on each bit. It samples MISO into the receive word
// and pushes each finished word unless discard is set.
// Assumes: tick is a one-cycle pulse; tx_data is valid while tx_empty is low.
module spi_eng_core
    import spi_eng_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              cpha,
    input  logic              cpol,
    input  logic              lsb_first,
    input  logic              drop_rx,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic              busy,
    output logic              done
);
    localparam int BIT_W = $clog2(WORD_W);
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(WORD_W - 1);

    eng_state_t        state;
    logic [CNT_W-1:0]  rem_burst, rem_tx;
    logic [WORD_W-1:0] sreg, rxb, rx_upd, rx_data_q, tx_word;
    logic [BIT_W-1:0]  bitcnt, cur_idx, nxt_idx, first_idx;
    logic              half, mosi_q, rx_push_q, need_tx, stall;

    function automatic logic [BIT_W-1:0] pick(input logic [BIT_W-1:0] n,
                                              input logic lsb);
        return lsb ? n : (LAST_BIT - n);
    endfunction

    // Word source, bit positions and the receive word with the bit being sampled.
    always_comb begin
        need_tx   = (rem_tx != '0);
        stall     = need_tx && tx_empty;
        tx_word   = need_tx ? tx_data : '0;
        cur_idx   = pick(bitcnt, lsb_first);
        nxt_idx   = pick(bitcnt + 1'b1, lsb_first);
        first_idx = pick('0, lsb_first);
        rx_upd    = rxb;
        rx_upd[cur_idx] = miso;
    end

    // Burst sequencing and bit shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rem_burst <= '0;
            rem_tx    <= '0;
            sreg      <= '0;
            rxb       <= '0;
            rx_data_q <= '0;
            bitcnt    <= '0;
            half      <= 1'b0;
            mosi_q    <= 1'b0;
            rx_push_q <= 1'b0;
        end else begin
            rx_push_q <= 1'b0;
            case (state)
                ST_IDLE: if (go) begin
                    rem_burst <= burst_len;
                    rem_tx    <= tx_len;
                    state     <= ST_LOAD;
                end
                ST_LOAD: begin
                    if (rem_burst == '0) begin
                        state <= ST_DONE;
                    end else if (!stall) begin
                        sreg   <= tx_word;
                        rxb    <= '0;
                        bitcnt <= '0;
                        half   <= 1'b0;
                        mosi_q <= tx_word[first_idx];
                        if (need_tx) rem_tx <= rem_tx - 1'b1;
                        state  <= ST_SHIFT;
                    end
                end
                ST_SHIFT: if (tick) begin
                    if (!half) begin
                        half <= 1'b1;
                        if (!cpha) rxb    <= rx_upd;
                        else       mosi_q <= sreg[cur_idx];
                    end else begin
                        half <= 1'b0;
                        if (cpha) rxb <= rx_upd;
                        if (bitcnt == LAST_BIT) begin
                            rx_push_q <= !drop_rx;
                            rx_data_q <= cpha ? rx_upd : rxb;
                            rem_burst <= rem_burst - 1'b1;
                            state     <= ST_LOAD;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            if (!cpha) mosi_q <= sreg[nxt_idx];
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign tx_pop  = (state == ST_LOAD) && (rem_burst != '0) && need_tx && !tx_empty;
    assign rx_push = rx_push_q;
    assign rx_data = rx_data_q;
    assign sclk    = cpol ^ half;
    assign mosi    = mosi_q;
    assign busy    = (state != ST_IDLE);
    assign done    = (state == ST_DONE);

    // R7: completion is a single-cycle pulse.
    a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10: while waiting to load a word, SCLK rests at idle.
    a_r10_stall_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_LOAD) |-> (sclk == cpol));
    // R4: no push follows a cycle with discard set.
    a_r4_no_push_when_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |-> !$past(drop_rx));
    // R3: the FIFO is never popped while empty.
    a_r3_pop_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty);
    // R11: no FIFO traffic from an idle engine.
    a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!tx_pop && !rx_push));
endmodule

// File: rtl/spi_eng_cs.sv
// Chip-select drive. Each line rests at the idle level, which equals the
// active-low bit. The selected line is asserted while a burst runs
// (automatic mode) or copies the manual level bit (manual mode).
// Assumes: sel < N_CS.
module spi_eng_cs #(
    parameter int N_CS  = 4,
    localparam int SEL_W = $clog2(N_CS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             act_lo,
    input  logic             manual,
    input  logic             man_lvl,
    input  logic [SEL_W-1:0] sel,
    input  logic             busy,
    output logic [N_CS-1:0]  cs_o
);
    logic sel_lvl;

    // Level driven onto the selected line.
    always_comb sel_lvl = manual ? man_lvl : (busy ? ~act_lo : act_lo);

    for (genvar i = 0; i < N_CS; i++) begin : g_line
        assign cs_o[i] = (sel == SEL_W'(i)) ? sel_lvl : act_lo;
    end

    // R8: at most one line is away from the idle level.
    a_r8_single_line: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cs_o ^ {N_CS{act_lo}}) <= 1);
    // R8: an automatic burst always asserts one line.
    a_r8_busy_asserts: assert property (@(posedge clk) disable iff (!rst_n)
        (!manual && busy) |-> (cs_o != {N_CS{act_lo}}));
endmodule

// File: rtl/spi_burst_engine.sv
// Top: control register, burst shifter and chip-select drive.
// Assumes: external FIFOs and an external tick generator.
module spi_burst_engine
    import spi_eng_pkg::*;
#(
    parameter int CNT_W  = 24,
    parameter int WORD_W = 8,
    parameter int N_CS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [CTL_W-1:0]  ctl_wdata,
    output logic [CTL_W-1:0]  ctl_q,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic [CNT_W-1:0]  tx_len,
    input  logic              tick,
    input  logic              tx_empty,
    input  logic [WORD_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [WORD_W-1:0] rx_data,
    output logic              sclk,
    output logic              mosi,
    input  logic              miso,
    output logic [N_CS-1:0]   cs_o,
    output logic              done
);
    localparam int SEL_W = $clog2(N_CS);

    logic go, busy;

    spi_eng_ctl u_ctl (
        .clk(clk), .rst_n(rst_n), .wr_en(ctl_we), .wr_data(ctl_wdata),
        .xfer_done(done), .ctl_q(ctl_q)
    );

    // A burst launches only when enabled and in master mode.
    always_comb go = ctl_q[CB_GO] && ctl_q[CB_EN] && ctl_q[CB_MST];

    spi_eng_core #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_core (
        .clk(clk), .rst_n(rst_n), .go(go),
        .cpha(ctl_q[CB_CPHA]), .cpol(ctl_q[CB_CPOL]),
        .lsb_first(ctl_q[CB_LSB]), .drop_rx(ctl_q[CB_DROP]),
        .burst_len(burst_len), .tx_len(tx_len), .tick(tick),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .busy(busy), .done(done)
    );

    spi_eng_cs #(.N_CS(N_CS)) u_cs (
        .clk(clk), .rst_n(rst_n), .act_lo(ctl_q[CB_ACTLO]),
        .manual(ctl_q[CB_MAN]), .man_lvl(ctl_q[CB_LVL]),
        .sel(ctl_q[CB_SEL +: SEL_W]), .busy(busy), .cs_o(cs_o)
    );
endmodule

// File: tb/spi_burst_engine_bench.sv
module spi_burst_engine_bench;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        ctl_we = 1'b0;
    logic [17:0] ctl_wdata = '0;
    logic [17:0] ctl_q;
    logic [23:0] burst_len = '0, tx_len = '0;
    logic        tick;
    logic        tx_empty, tx_pop, rx_push, sclk, mosi, miso, done;
    logic [7:0]  tx_data, rx_data;
    logic [3:0]  cs_o;

    spi_burst_engine u_spi_burst_engine (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_q(ctl_q), .burst_len(burst_len), .tx_len(tx_len), .tick(tick),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .sclk(sclk), .mosi(mosi),
        .miso(miso), .cs_o(cs_o), .done(done)
    );

    assign miso = mosi;  // loopback

    int total = 0, bad = 0;
    int cycles = 0;

    // tick every third cycle
    logic [1:0] tdiv;
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin tdiv <= 2'd0; tick <= 1'b0; end
        else begin tdiv <= (tdiv == 2'd2) ? 2'd0 : tdiv + 2'd1; tick <= (tdiv == 2'd2); end
    end

    // transmit FIFO model
    logic [7:0] txq [0:1023];
    int tx_wr = 0, tx_rd = 0;
    assign tx_empty = (tx_wr == tx_rd);
    assign tx_data  = txq[tx_rd % 1024];
    always @(posedge clk) if (tx_pop) tx_rd <= tx_rd + 1;

    // receive FIFO model and completion counter
    logic [7:0] rxq [0:1023];
    int rx_n = 0, done_cnt = 0;
    always @(posedge clk) begin
        if (rx_push) begin rxq[rx_n % 1024] <= rx_data; rx_n <= rx_n + 1; end
        if (done) done_cnt <= done_cnt + 1;
    end

    // MOSI monitor at the sampling edge expected for the current mode
    bit mon_bits [0:8191];
    int mon_n = 0;
    bit mon_en = 0, cur_cpol = 0, cur_cpha = 0;
    logic prev_sclk = 1'b0;
    always @(negedge clk) begin
        if (mon_en && sclk !== prev_sclk) begin
            if (((sclk != cur_cpol) && !cur_cpha) || ((sclk == cur_cpol) && cur_cpha)) begin
                mon_bits[mon_n % 8192] = mosi;
                mon_n = mon_n + 1;
            end
        end
        prev_sclk = sclk;
    end

    logic [7:0] expb [0:255];
    int exp_n, rx_base, mon_base, done_base, txrd_base;

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic step();
        @(posedge clk); #2;
    endtask

    task automatic write_ctl(input logic [17:0] v);
        ctl_wdata = v; ctl_we = 1'b1; step(); ctl_we = 1'b0;
    endtask

    function automatic logic [17:0] mk(input bit en, input bit mst, input bit cpha,
            input bit cpol, input bit actlo, input bit lsb, input bit go,
            input bit [1:0] sel, input bit drop, input bit man, input bit lvl);
        logic [17:0] v = '0;
        v[0] = en; v[1] = mst; v[2] = cpha; v[3] = cpol; v[4] = actlo;
        v[6] = lsb; v[10] = go; v[13:12] = sel; v[15] = drop; v[16] = man; v[17] = lvl;
        return v;
    endfunction

    task automatic push(input int n);
        for (int i = 0; i < n; i++) begin
            logic [7:0] b = 8'($urandom);
            txq[tx_wr % 1024] = b; tx_wr++;
            expb[exp_n] = b; exp_n++;
        end
    endtask

    task automatic start(input logic [17:0] cfg, input int nb, input int nt);
        burst_len = 24'(nb); tx_len = 24'(nt);
        mon_en = 0;
        cur_cpol = cfg[3]; cur_cpha = cfg[2];
        write_ctl(cfg);
        step();
        rx_base = rx_n; mon_base = mon_n; done_base = done_cnt; txrd_base = tx_rd;
        mon_en = 1;
        write_ctl(cfg | 18'h00400);
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int i = 0; i < 20000 && !seen; i++) begin
            if (done_cnt > done_base) seen = 1;
            else step();
        end
        chk(seen, "R7 completion seen", int'(seen), 1);
        for (int i = 0; i < 4; i++) step();
    endtask

    task automatic finish_check(input logic [17:0] cfg, input int nb);
        logic [3:0] idle = cfg[4] ? 4'hF : 4'h0;
        for (int i = exp_n; i < nb; i++) expb[i] = 8'h00;
        chk(mon_n - mon_base == 8 * nb, "R2 sampling edges", mon_n - mon_base, 8 * nb);
        for (int k = 0; k < nb; k++) begin
            logic [7:0] v = '0;
            for (int j = 0; j < 8; j++)
                if (cfg[6]) v[j] = mon_bits[(mon_base + 8*k + j) % 8192];
                else        v[7-j] = mon_bits[(mon_base + 8*k + j) % 8192];
            chk(v == expb[k], "R3 R6 word on MOSI", int'(v), int'(expb[k]));
        end
        if (cfg[15]) chk(rx_n == rx_base, "R4 discard", rx_n - rx_base, 0);
        else begin
            chk(rx_n - rx_base == nb, "R4 push count", rx_n - rx_base, nb);
            for (int k = 0; k < nb; k++)
                chk(rxq[(rx_base + k) % 1024] == expb[k], "R4 received word",
                    int'(rxq[(rx_base + k) % 1024]), int'(expb[k]));
        end
        chk(done_cnt - done_base == 1, "R7 single pulse", done_cnt - done_base, 1);
        chk(ctl_q[10] == 1'b0, "R7 start cleared", int'(ctl_q[10]), 0);
        chk(sclk == cfg[3], "R5 idle polarity", int'(sclk), int'(cfg[3]));
        if (!cfg[16]) chk(cs_o == idle, "R8 idle select", int'(cs_o), int'(idle));
        mon_en = 0;
    endtask

    task automatic run(input logic [17:0] cfg, input int nb, input int nt);
        logic [3:0] act;
        exp_n = 0;
        push((nt < nb) ? nt : nb);
        start(cfg, nb, nt);
        if (nb > 0 && !cfg[16]) begin
            for (int i = 0; i < 6; i++) step();
            act = cfg[4] ? ~(4'b1 << cfg[13:12]) : (4'b1 << cfg[13:12]);
            chk(cs_o == act, "R8 active select", int'(cs_o), int'(act));
        end
        wait_done();
        finish_check(cfg, nb);
    endtask

    // watchdog
    initial begin
        wait (cycles > 150000);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [17:0] c;
        void'($urandom(32'd4242));
        for (int i = 0; i < 4; i++) step();
        // R12 reset state
        chk(ctl_q == 18'h0, "R12 ctl", int'(ctl_q), 0);
        chk(sclk == 1'b0, "R12 sclk", int'(sclk), 0);
        chk(cs_o == 4'h0, "R12 cs", int'(cs_o), 0);
        chk(!done && !tx_pop && !rx_push, "R12 strobes", int'({done, tx_pop, rx_push}), 0);
        rst_n = 1'b1;
        step();

        // R1: start without enable, then without master
        for (int m = 0; m < 2; m++) begin
            c = mk(m == 1, m == 0, 0, 0, 1, 0, 0, 2'd0, 0, 0, 0);
            exp_n = 0;
            start(c, 2, 0);
            for (int i = 0; i < 300; i++) step();
            chk(mon_n == mon_base, "R1 no clocking", mon_n - mon_base, 0);
            chk(done_cnt == done_base, "R1 no completion", done_cnt - done_base, 0);
            chk(ctl_q[10] == 1'b1, "R1 start stays", int'(ctl_q[10]), 1);
            write_ctl(18'h0);
            mon_en = 0;
        end

        // R5 R6: all modes, both orders
        for (int md = 0; md < 8; md++) begin
            c = mk(1, 1, md[0], md[1], md[2], md[2], 0, 2'(md), 0, 0, 0);
            run(c, 3, 3);
        end
        // R5 idle level with polarity set
        write_ctl(mk(1, 1, 0, 1, 1, 0, 0, 2'd1, 0, 0, 0));
        step();
        chk(sclk == 1'b1, "R5 idle high", int'(sclk), 1);

        // R3 padding past the transmit count
        run(mk(1, 1, 1, 0, 1, 0, 0, 2'd3, 0, 0, 0), 5, 2);
        run(mk(1, 1, 0, 0, 0, 1, 0, 2'd2, 0, 0, 0), 3, 0);
        // R4 discard
        run(mk(1, 1, 0, 1, 1, 0, 0, 2'd1, 1, 0, 0), 3, 3);
        // R11 zero burst
        run(mk(1, 1, 0, 0, 1, 0, 0, 2'd0, 0, 0, 0), 0, 0);

        // R10 stall on empty FIFO
        c = mk(1, 1, 0, 1, 1, 0, 0, 2'd2, 0, 0, 0);
        exp_n = 0;
        push(2);
        start(c, 4, 4);
        for (int i = 0; i < 400; i++) step();
        chk(mon_n - mon_base == 16, "R10 stalled after data", mon_n - mon_base, 16);
        chk(sclk == 1'b1, "R10 sclk idle in stall", int'(sclk), 1);
        chk(done_cnt == done_base, "R10 not complete", done_cnt - done_base, 0);
        chk(tx_rd - txrd_base == 2, "R10 pops", tx_rd - txrd_base, 2);
        push(2);
        wait_done();
        finish_check(c, 4);

        // R9 manual chip select
        write_ctl(mk(1, 1, 0, 0, 1, 0, 0, 2'd2, 0, 1, 0));
        step();
        chk(cs_o == 4'b1011, "R9 manual low", int'(cs_o), 11);
        write_ctl(mk(1, 1, 0, 0, 0, 0, 0, 2'd1, 0, 1, 1));
        step();
        chk(cs_o == 4'b0010, "R9 manual high", int'(cs_o), 2);
        c = mk(1, 1, 0, 0, 0, 0, 0, 2'd3, 0, 1, 0);
        exp_n = 0;
        push(2);
        start(c, 2, 2);
        for (int i = 0; i < 10; i++) step();
        chk(cs_o == 4'b0000, "R9 manual held in burst", int'(cs_o), 0);
        wait_done();
        finish_check(c, 2);

        // random bursts
        for (int t = 0; t < 20; t++) begin
            int nb = 1 + int'($urandom % 6);
            int nt = int'($urandom % (nb + 1));
            logic [3:0] r = 4'($urandom);
            c = mk(1, 1, r[0], r[1], r[2], r[3], 0, 2'($urandom), ($urandom % 4) == 0, 0, 0);
            run(c, nb, nt);
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule